// File: doc/BRIEF.md
# Log-Domain Otsu Threshold Unit

The block finds an automatic binarisation threshold for one frame of 8-bit values, such as thinned gradient magnitudes in an edge detector. While a frame streams in, every accepted value bumps its bin in an internal 256-entry count memory. After a frame-end pulse the unit walks the bins in ascending order. It keeps running sums of class probability and class mean in unsigned fixed point with 24 fraction bits, and scores every candidate split. Each score is the between-class variance taken in the base-2 log domain, so a subtraction of logarithms stands where a divider would otherwise be needed. The logarithms come from a leading-zero count followed by a normalising shift.

A frame always holds exactly 2^LOG2_PIX values. The bin probability is therefore the count shifted left by 24 − LOG2_PIX, and the global mean is the sum of all values shifted by the same amount. The unit reports the split just before the first drop in score as the high threshold, half of it as the low threshold, and a one-cycle done strobe. The same walk writes zero into each bin it reads, so the count memory is empty again for the next frame.

Control is one state machine with six states:
- ST_WIPE is entered from reset and zeroes all bins, one per cycle. It moves to ST_COLLECT after the last bin.
- ST_COLLECT accepts values and moves to ST_SETTLE when frame_end is high.
- ST_SETTLE lets the last count write land, clears the running sums, and always moves to ST_SCAN.
- ST_SCAN reads and clears one bin per cycle and moves to ST_DRAIN after the last bin.
- ST_DRAIN waits until the last bin's score has been compared, then moves to ST_REPORT.
- ST_REPORT publishes the result and always returns to ST_COLLECT.

Top module: `lgotsu_thresh`

## Requirements
- R1: After reset, thr_done, thr_high and thr_low are all 0.
- R2: Every value accepted in ST_COLLECT adds exactly one to its bin, including the same value on back-to-back cycles and in long runs.
- R3: pix_valid and pix_value have no effect outside ST_COLLECT. Values offered during the sweep do not change the result of that frame or of the next one.
- R4: Bins are visited in ascending order 0 to 255. For bin k: p = count·2^(24−LOG2_PIX); w accumulates p; u accumulates k·p; the global mean uG is the value sum·2^(24−LOG2_PIX).
- R5: The score of bin k is 2·L(d) − L(w) − L(2^24 − w), where d = floor(uG·w / 2^24) − u. L(x) is a 21-bit code: bits 20:16 give the bit position of the leading one of the 32-bit x, and bits 15:0 are the 16 bits just below that leading one (a linear log fraction).
- R6: A bin is minus infinity, with no score, when w is 0, when w is 2^24, or when d ≤ 0.
- R7: thr_high = k − 1 for the first k ≥ 1 where the previous bin is finite and the current bin is either minus infinity or has a score strictly below the previous score. If no such k exists, thr_high is 0.
- R8: thr_low equals thr_high shifted right by one.
- R9: thr_done is high for exactly one cycle per frame. thr_high and thr_low change only in that cycle and hold their values otherwise.
- R10: The sweep leaves every bin at zero, so each frame's result depends only on that frame's values.
- R11: thr_done goes high at the 261st rising edge after the edge that samples frame_end (NBINS + 5 edges).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_valid | input | 1 | pix_value carries a frame value this cycle |
| pix_value | input | PIX_W | Value to be counted |
| frame_end | input | 1 | Last value of the frame has been offered; start the sweep |
| thr_high | output | PIX_W | High threshold from the log-domain variance search |
| thr_low | output | PIX_W | Half of thr_high |
| thr_done | output | 1 | One-cycle strobe when new thresholds are valid |

## Verification
Three properties are checked on every cycle by assertions. Two same-bin increments in a row must raise the written count by exactly one. Outside collection, the memory is only ever written with zero. The sweep index must step by one between consecutive reads. Assertions also check the single-cycle done strobe and the hold of both thresholds between strobes. Only the bench scenarios can show that the threshold itself is right, because it needs a full arithmetic model of the sums, the log code and the first-drop rule over whole frames. The same holds for the fixed latency, and for junk values offered mid-sweep leaving both the current frame and the next one unchanged.

// File: rtl/lgotsu_pkg.sv
`timescale 1ns/1ps
package lgotsu_pkg;
    typedef enum logic [2:0] {
        ST_WIPE,
        ST_COLLECT,
        ST_SETTLE,
        ST_SCAN,
        ST_DRAIN,
        ST_REPORT
    } lgotsu_state_t;
endpackage

// File: rtl/lgotsu_bin_ram.sv
`timescale 1ns/1ps
module lgotsu_bin_ram #(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // A read returns the contents from before a write in the same cycle.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
        rd_data <= mem[rd_addr];
    end
endmodule

// File: rtl/lgotsu_log2.sv
`timescale 1ns/1ps
module lgotsu_log2 #(
    parameter int FW = 16
) (
    input  logic [31:0]   x_i,
    output logic [4+FW:0] lg_o
);
    logic [4:0]  pos;
    logic [31:0] norm;

    // Position of the leading one (this equals 31 minus the leading-zero count).
    always_comb begin
        pos = '0;
        for (int b = 0; b < 32; b++) begin
            if (x_i[b]) pos = 5'(b);
        end
    end

    // Shift the leading one up to bit 31. The bits below it give the linear fraction.
    assign norm = x_i << (5'd31 - pos);
    assign lg_o = {pos, FW'(norm >> (31 - FW))};

    always_comb begin
        if (x_i != 32'd0) AST_NORM_LEADING: assert (norm[31]); // R5
    end
endmodule

// File: rtl/lgotsu_thresh.sv
`timescale 1ns/1ps
module lgotsu_thresh import lgotsu_pkg::*; #(
    parameter int PIX_W    = 8,
    parameter int LOG2_PIX = 18,
    parameter int LOG_FW   = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pix_valid,
    input  logic [PIX_W-1:0] pix_value,
    input  logic             frame_end,
    output logic [PIX_W-1:0] thr_high,
    output logic [PIX_W-1:0] thr_low,
    output logic             thr_done
);
    localparam int CNT_W = 32;
    localparam int QF    = 24;
    localparam int SH    = QF - LOG2_PIX;
    localparam int SUM_W = PIX_W + LOG2_PIX;
    localparam int LW    = 5 + LOG_FW;
    localparam int MW    = LW + 3;
    localparam logic [31:0]      ONE      = 32'd1 << QF;
    localparam logic [PIX_W-1:0] LAST_BIN = '1;

    lgotsu_state_t state, state_nx;
    logic [PIX_W-1:0] scan_k;

    // Count memory ports
    logic [PIX_W-1:0] rd_addr, wr_addr;
    logic [CNT_W-1:0] rd_data, wr_data;
    logic             wr_en;

    // Collection pipeline and forwarding of the last write
    logic             c1_v, wl_v;
    logic [PIX_W-1:0] c1_a, wl_a;
    logic [CNT_W-1:0] wl_d, cnt_base, cnt_inc;
    logic [SUM_W-1:0] sumv;

    // Sweep pipeline
    logic             s1_v, s2_v, s3_v, s3_fin, prev_fin, found, step_down;
    logic [PIX_W-1:0] s1_k, s2_k, s3_k, best;
    logic [31:0]      prob, w_acc, u_acc, ug, scaled;
    logic [32:0]      diff;
    logic             fin;
    logic [MW-1:0]    metric, s3_m, prev_m;
    logic [31:0]      lg_in  [3];
    logic [LW-1:0]    lg_out [3];

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (rst) state <= ST_WIPE;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_WIPE:    if (scan_k == LAST_BIN) state_nx = ST_COLLECT;
            ST_COLLECT: if (frame_end) state_nx = ST_SETTLE;
            ST_SETTLE:  state_nx = ST_SCAN;
            ST_SCAN:    if (scan_k == LAST_BIN) state_nx = ST_DRAIN;
            ST_DRAIN:   if (s3_v && s3_k == LAST_BIN) state_nx = ST_REPORT;
            ST_REPORT:  state_nx = ST_COLLECT;
            default:    state_nx = ST_WIPE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) scan_k <= '0;
        else if (state == ST_WIPE || state == ST_SCAN) scan_k <= scan_k + 1'b1;
    end

    // ---------------- histogram ----------------
    assign rd_addr  = (state == ST_SCAN) ? scan_k : pix_value;
    assign cnt_base = (wl_v && wl_a == c1_a) ? wl_d : rd_data;
    assign cnt_inc  = cnt_base + 1'b1;

    always_comb begin
        wr_en   = 1'b0;
        wr_addr = scan_k;
        wr_data = '0;
        if (c1_v) begin
            wr_en   = 1'b1;
            wr_addr = c1_a;
            wr_data = cnt_inc;
        end else if (state == ST_WIPE || state == ST_SCAN) begin
            wr_en = 1'b1;
        end
    end

    lgotsu_bin_ram #(.AW(PIX_W), .DW(CNT_W)) u_bins (
        .clk(clk), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            c1_v <= 1'b0; c1_a <= '0;
            wl_v <= 1'b0; wl_a <= '0; wl_d <= '0;
            sumv <= '0;
        end else begin
            c1_v <= (state == ST_COLLECT) && pix_valid;
            c1_a <= pix_value;
            wl_v <= wr_en;
            wl_a <= wr_addr;
            wl_d <= wr_data;
            if (state == ST_REPORT) sumv <= '0;
            else if (state == ST_COLLECT && pix_valid) sumv <= sumv + SUM_W'(pix_value);
        end
    end

    // ---------------- sweep stage A: running sums ----------------
    assign prob = rd_data << SH;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_v <= 1'b0; s1_k <= '0; s2_v <= 1'b0; s2_k <= '0;
            w_acc <= '0; u_acc <= '0;
        end else begin
            s1_v <= (state == ST_SCAN);
            s1_k <= scan_k;
            s2_v <= s1_v;
            s2_k <= s1_k;
            if (state == ST_SETTLE) begin
                w_acc <= '0;
                u_acc <= '0;
            end else if (s1_v) begin
                w_acc <= w_acc + prob;
                u_acc <= u_acc + 32'(s1_k) * prob;
            end
        end
    end

    // ---------------- sweep stage B: log-domain score ----------------
    assign ug     = 32'(sumv) << SH;
    assign scaled = 32'((64'(ug) * 64'(w_acc)) >> QF);
    assign diff   = {1'b0, scaled} - {1'b0, u_acc};
    assign fin    = (w_acc != '0) && (w_acc != ONE) && !diff[32] && (diff[31:0] != '0);
    assign lg_in[0] = diff[31:0];
    assign lg_in[1] = w_acc;
    assign lg_in[2] = ONE - w_acc;

    for (genvar g = 0; g < 3; g++) begin : g_log
        lgotsu_log2 #(.FW(LOG_FW)) u_lg (.x_i(lg_in[g]), .lg_o(lg_out[g]));
    end

    assign metric = (MW'(lg_out[0]) << 1) - MW'(lg_out[1]) - MW'(lg_out[2]);

    always_ff @(posedge clk) begin
        if (rst) begin
            s3_v <= 1'b0; s3_k <= '0; s3_fin <= 1'b0; s3_m <= '0;
        end else begin
            s3_v   <= s2_v;
            s3_k   <= s2_k;
            s3_fin <= fin;
            s3_m   <= metric;
        end
    end

    // ---------------- sweep stage C: first drop ----------------
    assign step_down = prev_fin && (!s3_fin || ($signed(s3_m) < $signed(prev_m)));

    always_ff @(posedge clk) begin
        if (rst || state == ST_SETTLE) begin
            found <= 1'b0; best <= '0; prev_fin <= 1'b0; prev_m <= '0;
        end else if (s3_v) begin
            if (s3_k != '0 && !found && step_down) begin
                found <= 1'b1;
                best  <= s3_k - 1'b1;
            end
            prev_fin <= s3_fin;
            prev_m   <= s3_m;
        end
    end

    // ---------------- outputs ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            thr_done <= 1'b0; thr_high <= '0; thr_low <= '0;
        end else begin
            thr_done <= (state == ST_REPORT);
            if (state == ST_REPORT) begin
                thr_high <= found ? best : '0;
                thr_low  <= found ? (best >> 1) : '0;
            end
        end
    end

    // ---------------- assertions ----------------
    AST_FWD_COUNT: assert property (@(posedge clk) disable iff (rst) (c1_v && $past(c1_v) && c1_a == $past(c1_a)) |-> cnt_inc == $past(cnt_inc) + 1'b1); // R2
    AST_CLEAR_ONLY: assert property (@(posedge clk) disable iff (rst) (wr_en && state != ST_COLLECT && state != ST_SETTLE) |-> wr_data == '0); // R3
    AST_SCAN_ASCEND: assert property (@(posedge clk) disable iff (rst) (s1_v && $past(s1_v)) |-> s1_k == $past(s1_k) + 1'b1); // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) thr_done |=> !thr_done); // R9
    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst) !thr_done |-> ($stable(thr_high) && $stable(thr_low))); // R9
endmodule

// File: tb/lgotsu_thresh_test.sv
`timescale 1ns/1ps
module lgotsu_thresh_test;
    localparam int     LP   = 8;
    localparam int     NPIX = 1 << LP;
    localparam int     SH   = 24 - LP;
    localparam longint ONE  = 64'd1 << 24;
    localparam int     LAT  = 262;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pix_valid = 1'b0;
    logic [7:0] pix_value = '0;
    logic       frame_end = 1'b0;
    logic [7:0] thr_high, thr_low;
    logic       thr_done;

    int          checks = 0;
    int          fails = 0;
    int          frame [NPIX];
    int unsigned seed = 32'h1234_5678;
    int          last_hi = 0;
    int          last_lo = 0;

    lgotsu_thresh #(.PIX_W(8), .LOG2_PIX(LP), .LOG_FW(16)) uut (
        .clk(clk), .rst(rst), .pix_valid(pix_valid), .pix_value(pix_value),
        .frame_end(frame_end), .thr_high(thr_high), .thr_low(thr_low), .thr_done(thr_done)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int rnd(input int m);
        seed = seed * 1103515245 + 12345;
        return int'((seed >> 16) % m);
    endfunction

    // 21-bit log code from R5: leading-one position above 16 bits below it
    function automatic longint lg2q(input longint x);
        int     p = 0;
        longint norm;
        for (int b = 0; b < 32; b++) if (x[b]) p = b;
        norm = (x << (31 - p)) & 64'hFFFF_FFFF;
        return longint'(p) * 65536 + ((norm >> 15) & 64'hFFFF);
    endfunction

    // Threshold from R4..R7 applied to the current frame
    function automatic int model_thr();
        longint hist [256];
        longint ug = 0, w = 0, u = 0, pr, d, m, prev_m = 0;
        bit     fin, prev_fin = 0, found = 0;
        int     res = 0;
        for (int k = 0; k < 256; k++) hist[k] = 0;
        for (int i = 0; i < NPIX; i++) begin
            hist[frame[i]]++;
            ug += frame[i];
        end
        ug = ug << SH;
        for (int k = 0; k < 256; k++) begin
            pr = hist[k] << SH;
            w += pr;
            u += k * pr;
            d = ((ug * w) >> 24) - u;
            fin = (w != 0) && (w != ONE) && (d > 0);
            m = fin ? 2 * lg2q(d) - lg2q(w) - lg2q(ONE - w) : 0;
            if (k != 0 && !found && prev_fin && (!fin || m < prev_m)) begin
                found = 1;
                res = k - 1;
            end
            prev_fin = fin;
            prev_m = m;
        end
        return res;
    endfunction

    task automatic run_frame(input string tag, input bit gaps, input bit junk);
        int exp_hi;
        int n;
        exp_hi = model_thr();
        for (int i = 0; i < NPIX; i++) begin
            if (gaps && (i % 5 == 2)) begin
                @(negedge clk);
                pix_valid = 1'b0;
            end
            @(negedge clk);
            pix_valid = 1'b1;
            pix_value = 8'(frame[i]);
            if (i == NPIX / 2) begin
                check({tag, " R9 hold high"}, int'(thr_high), last_hi);
                check({tag, " R9 hold low"}, int'(thr_low), last_lo);
            end
        end
        @(negedge clk);
        pix_valid = 1'b0;
        frame_end = 1'b1;
        @(negedge clk);
        frame_end = 1'b0;
        n = 1;
        while (!thr_done && n < 600) begin
            if (junk) begin
                pix_valid = 1'b1;
                pix_value = 8'(rnd(256));
            end
            @(negedge clk);
            n++;
        end
        pix_valid = 1'b0;
        check({tag, " R11 latency"}, n, LAT);
        check({tag, " R7 high"}, int'(thr_high), exp_hi);
        check({tag, " R8 low"}, int'(thr_low), exp_hi >> 1);
        last_hi = exp_hi;
        last_lo = exp_hi >> 1;
        @(negedge clk);
        check({tag, " R9 single pulse"}, int'(thr_done), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 done after reset", int'(thr_done), 0);
        check("R1 high after reset", int'(thr_high), 0);
        check("R1 low after reset", int'(thr_low), 0);
        repeat (NPIX + 4) @(negedge clk);

        for (int i = 0; i < NPIX; i++) frame[i] = (i < 100) ? 40 : 200;
        run_frame("R4 R6 two-level", 1'b0, 1'b0);

        for (int i = 0; i < NPIX; i++) frame[i] = (i < 100) ? 30 : ((i < 160) ? 120 : 220);
        run_frame("R2 runs three-level", 1'b0, 1'b0);

        for (int i = 0; i < NPIX; i++) frame[i] = i;
        run_frame("R5 ramp", 1'b0, 1'b0);

        for (int i = 0; i < NPIX; i++) frame[i] = 77;
        run_frame("R6 flat", 1'b0, 1'b0);
        check("R7 flat frame gives zero", int'(thr_high), 0);

        for (int i = 0; i < NPIX; i++) frame[i] = (i % 2 == 0) ? 0 : 255;
        run_frame("R2 alternating extremes", 1'b0, 1'b0);

        for (int i = 0; i < NPIX; i++) frame[i] = (i % 4 == 0) ? 180 + rnd(60) : 20 + rnd(50);
        run_frame("R3 junk during sweep", 1'b1, 1'b1);

        for (int i = 0; i < NPIX; i++) frame[i] = (i < 64) ? 10 + rnd(20) : 90 + rnd(100);
        run_frame("R3 R10 frame after junk", 1'b0, 1'b0);

        for (int f = 0; f < 28; f++) begin
            int c1, c2, sp, run;
            c1 = rnd(100);
            c2 = 120 + rnd(100);
            sp = 1 + rnd(35);
            run = 0;
            for (int i = 0; i < NPIX; i++) begin
                if (run == 0) run = 1 + rnd(8);
                if (f % 3 == 0 && run > 1 && i > 0) frame[i] = frame[i-1];
                else frame[i] = (rnd(3) == 0) ? c2 + rnd(sp) : c1 + rnd(sp);
                run--;
            end
            run_frame("R7 R10 random bimodal", f[0], 1'b0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #750000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule